// File: doc/BRIEF.md
# Pointer and Stack Address Generator

This block forms the effective address of every indirect data-memory access made by a small 8-bit processor core. The pointer values come from the register file, which this block does not hold. The three 16-bit pointers are called X, Y and Z. They are fed in as three separate inputs. The block itself keeps the 8-bit stack pointer.

An access is requested with a one-cycle `start` strobe. The strobe carries an access mode, a pointer select and a 6-bit displacement. The block latches the request and drives the effective address for the whole access. It raises `busy` for the fixed number of cycles that the access form takes. In the final cycle it presents one of two updates: the new pointer value together with its register-pair index, or the stack-pointer update.

The decoder drives this block. The data or program memory uses `addr` while `busy` is high. The register file takes the pointer writeback when `ptr_wb_en` is high.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset, `busy`, `last`, `ptr_wb_en`, `sp_wr` and `prog_rd` are 0, and `sp_val` equals the parameter SP_INIT (default 8'hFF).
- R2: Mode 0 (plain indirect) drives `addr` with the selected pointer and performs no writeback. The `psel` encoding is 0 = X, 1 = Y, 2 = Z, and 3 is treated as Z.
- R3: Mode 1 (post-increment) drives `addr` with the pointer. In the last cycle it writes back the pointer plus one, wrapping modulo 65536. The writeback goes to `ptr_wb_reg`, which is the low register of the pair: 26 for X, 28 for Y, 30 for Z.
- R4: Mode 2 (pre-decrement) drives both `addr` and the writeback value with the pointer minus one, wrapping modulo 65536.
- R5: Mode 3 (displacement) drives `addr` with Y or Z plus the unsigned 6-bit `disp`, and the pointer is left unchanged. When X is selected, the displacement is ignored and `addr` equals X.
- R6: Mode 7 (direct) drives `addr` with `direct_addr`. Every data-memory form keeps `busy` high for exactly 2 cycles, and `last` is high in the second of them.
- R7: Mode 4 (push) drives `addr` with {8'h00, SP}, and SP then decrements. Mode 5 (pop) increments SP first and addresses the new value. SP wraps modulo 256 and changes at the edge that ends the last cycle.
- R8: Mode 6 (program read) always addresses Z, whatever `psel` is. It raises `prog_rd` while busy and lasts exactly 3 cycles.
- R9: A `start` that arrives while `busy` is high is ignored, and the current access keeps its address.
- R10: `ptr_wb_en` is high only in the last cycle of modes 1 and 2. `sp_wr` is high only in the last cycle of modes 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when not busy |
| mode | input | 3 | Access form (see R2 to R8) |
| psel | input | 2 | Pointer select: 0 X, 1 Y, 2/3 Z |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Address for direct mode |
| ptr_x | input | 16 | Current X pointer value |
| ptr_y | input | 16 | Current Y pointer value |
| ptr_z | input | 16 | Current Z pointer value |
| busy | output | 1 | Access in progress |
| last | output | 1 | Final cycle of the access |
| addr | output | 16 | Effective address, valid while busy |
| prog_rd | output | 1 | Address targets program memory |
| ptr_wb_en | output | 1 | Pointer writeback strobe |
| ptr_wb_reg | output | 5 | Low register index of the pair written back |
| ptr_wb_data | output | 16 | New pointer value |
| sp_val | output | 8 | Current stack pointer |
| sp_wr | output | 1 | Stack pointer updates at the end of this cycle |
| sp_nxt | output | 8 | Value the stack pointer takes |

## Verification
A request is taken at the rising edge where `start` is high and the block is idle. `addr`, `prog_rd` and `busy` take their new values right after that edge. `last`, together with the writeback or SP strobe, follows one edge later for data forms and two edges later for program reads. `sp_val` shows its new value only after the edge that ends the last cycle. The bench steps a behavioural model at each rising edge. It compares every output at the falling edge, so each result is checked in the cycle it is due, and one cycle early or late is reported.

// File: rtl/pag_pkg.sv
package pag_pkg;

  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_PUSH    = 3'd4,
    AM_POP     = 3'd5,
    AM_PROG    = 3'd6,
    AM_DIRECT  = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    PS_X    = 2'd0,
    PS_Y    = 2'd1,
    PS_Z    = 2'd2,
    PS_ZALT = 2'd3
  } psel_e;

  // forms that write the pointer back to its register pair
  function automatic logic f_ptr_wb(amode_e m);
    return (m == AM_POSTINC) || (m == AM_PREDEC);
  endfunction

  // forms that move the stack pointer
  function automatic logic f_stack(amode_e m);
    return (m == AM_PUSH) || (m == AM_POP);
  endfunction

  // displacement honoured only on Y and Z
  function automatic logic f_disp_ok(psel_e s);
    return s != PS_X;
  endfunction

  // pair index 0/1/2 for X/Y/Z; code 3 folds onto Z
  function automatic logic [1:0] f_pair(psel_e s);
    return (s == PS_ZALT) ? 2'd2 : s;
  endfunction

endpackage

// File: rtl/pag_calc.sv
module pag_calc
  import pag_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int SP_W      = 8,
  parameter int DISP_W    = 6,
  parameter int REG_W     = 5,
  parameter int PAIR_BASE = 26,
  parameter int DATA_CYC  = 2,
  parameter int PROG_CYC  = 3,
  parameter int CNT_W     = 2
) (
  input  amode_e             mode_i,
  input  psel_e              psel_i,
  input  logic [DISP_W-1:0]  disp_i,
  input  logic [PTR_W-1:0]   daddr_i,
  input  logic [PTR_W-1:0]   px_i,
  input  logic [PTR_W-1:0]   py_i,
  input  logic [PTR_W-1:0]   pz_i,
  input  logic [SP_W-1:0]    sp_i,
  output logic [PTR_W-1:0]   addr_o,
  output logic [PTR_W-1:0]   wb_data_o,
  output logic [REG_W-1:0]   wb_reg_o,
  output logic               wb_flag_o,
  output logic [SP_W-1:0]    sp_next_o,
  output logic               sp_flag_o,
  output logic               prog_o,
  output logic [CNT_W-1:0]   ncyc_o
);

  localparam int PAD_W = PTR_W - SP_W;

  logic [PTR_W-1:0] base;
  logic [SP_W-1:0]  sp_inc;
  logic [1:0]       pair;

  assign pair   = f_pair(psel_i);
  assign sp_inc = sp_i + SP_W'(1);

  always_comb begin
    unique case (pair)
      2'd0:    base = px_i;
      2'd1:    base = py_i;
      default: base = pz_i;
    endcase
  end

  always_comb begin
    addr_o    = base;
    wb_data_o = base;
    wb_flag_o = f_ptr_wb(mode_i);
    sp_next_o = sp_i;
    sp_flag_o = f_stack(mode_i);
    prog_o    = 1'b0;
    unique case (mode_i)
      AM_POSTINC: wb_data_o = base + PTR_W'(1);
      AM_PREDEC: begin
        addr_o    = base - PTR_W'(1);
        wb_data_o = base - PTR_W'(1);
      end
      AM_DISP: if (f_disp_ok(psel_i)) addr_o = base + PTR_W'(disp_i);
      AM_PUSH: begin
        addr_o    = {{PAD_W{1'b0}}, sp_i};
        sp_next_o = sp_i - SP_W'(1);
      end
      AM_POP: begin
        addr_o    = {{PAD_W{1'b0}}, sp_inc};
        sp_next_o = sp_inc;
      end
      AM_PROG: begin
        addr_o = pz_i;
        prog_o = 1'b1;
      end
      AM_DIRECT: addr_o = daddr_i;
      default: ;
    endcase
  end

  assign wb_reg_o = REG_W'(PAIR_BASE) + REG_W'({pair, 1'b0});
  assign ncyc_o   = (mode_i == AM_PROG) ? CNT_W'(PROG_CYC) : CNT_W'(DATA_CYC);

endmodule

// File: rtl/pag_seq.sv
module pag_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] ncyc_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  assign accept_o = start_i && (cnt_q == '0);
  assign busy_o   = cnt_q != '0;
  assign last_o   = cnt_q == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (accept_o)   cnt_q <= ncyc_i;
    else if (busy_o)     cnt_q <= cnt_q - CNT_W'(1);
  end

endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import pag_pkg::*;
#(
  parameter int          PTR_W     = 16,
  parameter int          SP_W      = 8,
  parameter int          DISP_W    = 6,
  parameter int          REG_W     = 5,
  parameter int          PAIR_BASE = 26,
  parameter int          DATA_CYC  = 2,
  parameter int          PROG_CYC  = 3,
  parameter logic [7:0]  SP_INIT   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [1:0]        psel,
  input  logic [DISP_W-1:0] disp,
  input  logic [PTR_W-1:0]  direct_addr,
  input  logic [PTR_W-1:0]  ptr_x,
  input  logic [PTR_W-1:0]  ptr_y,
  input  logic [PTR_W-1:0]  ptr_z,
  output logic              busy,
  output logic              last,
  output logic [PTR_W-1:0]  addr,
  output logic              prog_rd,
  output logic              ptr_wb_en,
  output logic [REG_W-1:0]  ptr_wb_reg,
  output logic [PTR_W-1:0]  ptr_wb_data,
  output logic [SP_W-1:0]   sp_val,
  output logic              sp_wr,
  output logic [SP_W-1:0]   sp_nxt
);

  localparam int MAX_CYC = (PROG_CYC > DATA_CYC) ? PROG_CYC : DATA_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [PTR_W-1:0] c_addr, c_wb_data;
  logic [REG_W-1:0] c_wb_reg;
  logic             c_wb_flag, c_sp_flag, c_prog;
  logic [SP_W-1:0]  c_sp_next;
  logic [CNT_W-1:0] c_ncyc;
  logic             accept;

  logic [PTR_W-1:0] addr_q, wb_data_q;
  logic [REG_W-1:0] wb_reg_q;
  logic             wb_flag_q, sp_flag_q, prog_q;
  logic [SP_W-1:0]  sp_next_q, sp_q;

  pag_calc #(
    .PTR_W(PTR_W), .SP_W(SP_W), .DISP_W(DISP_W), .REG_W(REG_W),
    .PAIR_BASE(PAIR_BASE), .DATA_CYC(DATA_CYC), .PROG_CYC(PROG_CYC),
    .CNT_W(CNT_W)
  ) u_calc (
    .mode_i    (amode_e'(mode)),
    .psel_i    (psel_e'(psel)),
    .disp_i    (disp),
    .daddr_i   (direct_addr),
    .px_i      (ptr_x),
    .py_i      (ptr_y),
    .pz_i      (ptr_z),
    .sp_i      (sp_q),
    .addr_o    (c_addr),
    .wb_data_o (c_wb_data),
    .wb_reg_o  (c_wb_reg),
    .wb_flag_o (c_wb_flag),
    .sp_next_o (c_sp_next),
    .sp_flag_o (c_sp_flag),
    .prog_o    (c_prog),
    .ncyc_o    (c_ncyc)
  );

  pag_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .ncyc_i   (c_ncyc),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last)
  );

  // request latched once, held for the whole access
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wb_data_q <= '0;
      wb_reg_q  <= '0;
      wb_flag_q <= 1'b0;
      sp_flag_q <= 1'b0;
      sp_next_q <= '0;
      prog_q    <= 1'b0;
    end else if (accept) begin
      addr_q    <= c_addr;
      wb_data_q <= c_wb_data;
      wb_reg_q  <= c_wb_reg;
      wb_flag_q <= c_wb_flag;
      sp_flag_q <= c_sp_flag;
      sp_next_q <= c_sp_next;
      prog_q    <= c_prog;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sp_q <= SP_W'(SP_INIT);
    else if (sp_wr) sp_q <= sp_next_q;
  end

  assign addr        = addr_q;
  assign prog_rd     = busy && prog_q;
  assign ptr_wb_en   = last && wb_flag_q;
  assign ptr_wb_reg  = wb_reg_q;
  assign ptr_wb_data = wb_data_q;
  assign sp_wr       = last && sp_flag_q;
  assign sp_nxt      = sp_next_q;
  assign sp_val      = sp_q;

endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
  parameter int PTR_W = 16,
  parameter int SP_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             last,
  input logic             prog_rd,
  input logic             ptr_wb_en,
  input logic             sp_wr,
  input logic [PTR_W-1:0] addr,
  input logic [SP_W-1:0]  sp_val,
  input logic [SP_W-1:0]  sp_nxt
);

  p_wb_in_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wb_en |-> last);

  p_sp_in_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |-> last);

  p_last_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> busy);

  p_idle_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(addr));

  p_sp_takes_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> (sp_val == $past(sp_nxt)));

  p_sp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_wr |=> $stable(sp_val));

  p_prog_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && prog_rd) |=> (busy && !last));

endmodule

bind ptr_addr_gen pag_checker #(.PTR_W(PTR_W), .SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .last      (last),
  .prog_rd   (prog_rd),
  .ptr_wb_en (ptr_wb_en),
  .sp_wr     (sp_wr),
  .addr      (addr),
  .sp_val    (sp_val),
  .sp_nxt    (sp_nxt)
);

// File: tb/tb_ptr_addr_gen.sv
module tb_ptr_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  psel = '0;
  logic [5:0]  disp = '0;
  logic [15:0] direct_addr = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic        busy, last, prog_rd, ptr_wb_en, sp_wr;
  logic [15:0] addr, ptr_wb_data;
  logic [4:0]  ptr_wb_reg;
  logic [7:0]  sp_val, sp_nxt;

  ptr_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .psel(psel),
    .disp(disp), .direct_addr(direct_addr), .ptr_x(ptr_x), .ptr_y(ptr_y),
    .ptr_z(ptr_z), .busy(busy), .last(last), .addr(addr), .prog_rd(prog_rd),
    .ptr_wb_en(ptr_wb_en), .ptr_wb_reg(ptr_wb_reg), .ptr_wb_data(ptr_wb_data),
    .sp_val(sp_val), .sp_wr(sp_wr), .sp_nxt(sp_nxt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  int    rem = 0, m_addr = 0, m_wb = 0, m_reg = 0, m_sp = 255, m_spn = 0;
  bit    m_wben = 0, m_stk = 0, m_prog = 0;
  string m_tag = "R2";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0; m_sp = 255;
    end else if (rem > 0) begin
      if (rem == 1 && m_stk) m_sp = m_spn;
      rem--;
    end else if (start) begin
      int p, s;
      s = (psel == 2'd3) ? 2 : int'(psel);
      p = (s == 0) ? int'(ptr_x) : (s == 1) ? int'(ptr_y) : int'(ptr_z);
      m_wben = 0; m_stk = 0; m_prog = 0; m_wb = p; m_addr = p;
      m_reg = 26 + 2 * s;
      rem = 2;
      case (mode)
        3'd0: m_tag = "R2";
        3'd1: begin m_tag = "R3"; m_wben = 1; m_wb = (p + 1) % 65536; end
        3'd2: begin m_tag = "R4"; m_wben = 1; m_addr = (p + 65535) % 65536; m_wb = m_addr; end
        3'd3: begin m_tag = "R5"; if (s != 0) m_addr = (p + int'(disp)) % 65536; end
        3'd4: begin m_tag = "R7"; m_stk = 1; m_addr = m_sp; m_spn = (m_sp + 255) % 256; end
        3'd5: begin m_tag = "R7"; m_stk = 1; m_spn = (m_sp + 1) % 256; m_addr = m_spn; end
        3'd6: begin m_tag = "R8"; m_prog = 1; m_addr = int'(ptr_z); rem = 3; end
        default: begin m_tag = "R6"; m_addr = int'(direct_addr); end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy == (rem > 0), "R6 busy", busy, rem > 0);
      chk(last == (rem == 1), (m_prog ? "R8 last" : "R6 last"), last, rem == 1);
      if (rem > 0) begin
        chk(int'(addr) == m_addr, m_tag, addr, m_addr);
        chk(prog_rd == m_prog, "R8 prog_rd", prog_rd, m_prog);
      end
      chk(ptr_wb_en == (rem == 1 && m_wben), "R10 wb_en", ptr_wb_en, rem == 1 && m_wben);
      if (rem == 1 && m_wben) begin
        chk(int'(ptr_wb_data) == m_wb, m_tag, ptr_wb_data, m_wb);
        chk(int'(ptr_wb_reg) == m_reg, "R3 wb_reg", ptr_wb_reg, m_reg);
      end
      chk(sp_wr == (rem == 1 && m_stk), "R10 sp_wr", sp_wr, rem == 1 && m_stk);
      chk(int'(sp_val) == m_sp, "R7 sp", sp_val, m_sp);
    end
  end

  task automatic op(input int md, input int sel, input int dp, input int da);
    @(negedge clk);
    mode = 3'(md); psel = 2'(sel); disp = 6'(dp); direct_addr = 16'(da);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (rem > 0) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // r1_ reset state
    chk(!busy && !last && !ptr_wb_en && !sp_wr && !prog_rd, "R1 idle", busy, 0);
    chk(sp_val == 8'hFF, "R1 sp init", sp_val, 8'hFF);

    ptr_x = 16'h0100; ptr_y = 16'h0200; ptr_z = 16'h03FE;
    op(0, 0, 0, 0); op(0, 1, 0, 0); op(0, 2, 0, 0); op(0, 3, 0, 0);   // R2
    op(1, 0, 0, 0);                                                   // R3
    ptr_z = 16'hFFFF; op(1, 2, 0, 0);                                 // R3 wrap
    op(2, 1, 0, 0);                                                   // R4
    ptr_x = 16'h0000; op(2, 0, 0, 0);                                 // R4 wrap
    ptr_x = 16'h0100; ptr_z = 16'h03FE;
    op(3, 1, 63, 0); op(3, 2, 0, 0);                                  // R5
    op(3, 0, 40, 0);                                                  // R5 X ignores disp
    op(7, 0, 0, 16'hA5A5);                                            // R6
    op(4, 0, 0, 0); op(5, 0, 0, 0);                                   // R7 push/pop
    op(5, 0, 0, 0);                                                   // R7 wrap up
    chk(sp_val == 8'h00, "R7 wrap pop", sp_val, 0);
    op(4, 0, 0, 0);                                                   // R7 wrap down
    chk(sp_val == 8'hFF, "R7 wrap push", sp_val, 8'hFF);
    op(6, 0, 0, 0);                                                   // R8 ignores psel

    // R9: second request during an access is dropped
    ptr_x = 16'h1234;
    @(negedge clk);
    mode = 3'd0; psel = 2'd0; start = 1'b1;
    @(negedge clk);
    mode = 3'd7; direct_addr = 16'hBEEF;
    @(negedge clk);
    start = 1'b0;
    chk(addr == 16'h1234, "R9 addr kept", addr, 16'h1234);
    while (rem > 0) @(negedge clk);
    repeat (2) @(negedge clk);

    done = 1;
    report();
    $finish;
  end
endmodule